// File: doc/BRIEF.md
# Halt-Aware Watchdog Timer

This block is the watchdog of a small microcontroller core. It counts ticks from one of two sources, picked by a strap: a free-running low-power tick that keeps running while the core sleeps, or the instruction-rate tick (one pulse per instruction cycle, that is one per four system clocks). If firmware does not restart it in time, it overflows and asks for a reset. What it asks for depends on the core's power state. A running core gets a full chip reset, and the timeout status flag is set. A halted core gets only a warm reset, which zeroes the program counter and the stack pointer.

The strap inputs (`cfg_enable`, `cfg_src`, `cfg_exp`) are wired to constants when the chip is built. They may change only while `rst_n` is low. The counter has two parts:

- A free-running prescaler. Only the external reset clears it.
- A one-bit "armed" stage. A firmware clear, a halt-entry strobe or the external reset clears it.

An overflow fires on the second prescaler wrap after the armed stage was last cleared. Because the prescaler is not cleared, the time to timeout after a clear falls between 2^n and 2^(n+1) ticks.

Top module: `wdog_core`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `chip_rst_req`, `warm_rst_req` and `timeout_flag` are all 0.
- R2: When `cfg_src`=0 only `slow_tick` advances the counter. When `cfg_src`=1 only `instr_tick` does. A tick on the unselected input has no effect.
- R3: With n = BASE_EXP + `cfg_exp`, where `cfg_exp` 00/01/10/11 adds 0/1/2/3 and BASE_EXP defaults to 12 (ratios 2^12..2^15), the first overflow after reset happens on the 2^(n+1)-th selected tick. With no clears in between, each later overflow follows the previous one after exactly 2^(n+1) ticks.
- R4: The prescaler counts selected ticks modulo 2^n from reset, and a clear does not touch it. After a clear, the next overflow lands on the second prescaler wrap. That is anywhere from 2^n+1 to 2^(n+1) ticks later.
- R5: An overflow while `halted`=0 makes `chip_rst_req` high for exactly one clock, in the cycle after the overflowing tick, with `warm_rst_req` low. In that same cycle `timeout_flag` reads 1.
- R6: An overflow while `halted`=1 makes `warm_rst_req` high for exactly one clock, in the cycle after the overflowing tick, with `chip_rst_req` low. `timeout_flag` keeps its value.
- R7: A `clr_wdt` strobe clears the armed stage and clears `timeout_flag`.
- R8: A `halt_enter` strobe clears the armed stage but leaves `timeout_flag` unchanged.
- R9: With `cfg_src`=1, the counter does not advance while `halted`=1, so no overflow can occur in halt. With `cfg_src`=0 it keeps counting in halt.
- R10: With `cfg_enable`=0 the counter never advances, no reset request is ever raised, `timeout_flag` stays 0, and `clr_wdt` and `halt_enter` have no effect.
- R11: A clear strobe in the same cycle as the tick that would overflow suppresses that overflow. The prescaler still advances on that tick.
- R12: Once set, `timeout_flag` stays 1 through later overflows (running or halted) and through `halt_enter`, until `rst_n` or `clr_wdt`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | External reset, active low, asynchronous |
| cfg_enable | input | 1 | Build-time strap: 1 enables the watchdog |
| cfg_src | input | 1 | Build-time strap: 0 selects the slow tick, 1 selects the instruction tick |
| cfg_exp | input | 2 | Build-time strap: timeout exponent offset added to BASE_EXP |
| slow_tick | input | 1 | Free-running low-power tick enable |
| instr_tick | input | 1 | Instruction-rate tick enable |
| clr_wdt | input | 1 | Firmware clear strobe |
| halt_enter | input | 1 | Strobe marking entry into halt |
| halted | input | 1 | High while the core is halted |
| chip_rst_req | output | 1 | One-cycle full chip reset request |
| warm_rst_req | output | 1 | One-cycle warm reset request (program counter and stack pointer) |
| timeout_flag | output | 1 | Set by a running-state overflow |

## Verification
The bench measures the tick distance to each overflow for all four exponent values. A divider with the wrong tap, or one that fires on the first wrap, shows up as an off-by-2x period. After a clear issued mid-period, it expects a shortened interval. A design that also cleared the prescaler would give a full 2^(n+1) instead. It drives a clear on the exact overflowing tick, where a wrong priority would emit a reset. It holds an instruction-sourced counter in halt for many ticks, where a missing freeze would produce a warm reset. It also checks that the flag survives halt entry and halted overflows, and that a disabled watchdog stays silent.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

  typedef enum logic {
    WD_SRC_SLOW  = 1'b0,
    WD_SRC_INSTR = 1'b1
  } wd_src_e;

  typedef enum logic [1:0] {
    WD_ACT_NONE = 2'd0,
    WD_ACT_CHIP = 2'd1,
    WD_ACT_WARM = 2'd2
  } wd_act_e;

  // Timeout exponent: base plus the strap offset.
  function automatic int unsigned wd_exp(input int unsigned base, input logic [1:0] sel);
    return base + int'(sel);
  endfunction

  // Reset action chosen for an overflow in a given power state.
  function automatic wd_act_e wd_action(input logic ovf, input logic is_halted);
    if (!ovf)      return WD_ACT_NONE;
    if (is_halted) return WD_ACT_WARM;
    return WD_ACT_CHIP;
  endfunction

endpackage

// File: rtl/wdog_tick_sel.sv
module wdog_tick_sel
  import wdog_pkg::*;
(
  input  logic cfg_enable,
  input  logic cfg_src,
  input  logic slow_tick,
  input  logic instr_tick,
  input  logic halted,
  output logic cnt_tick
);

  logic src_tick;

  // The instruction tick stops with the system clock in halt.
  always_comb begin
    case (wd_src_e'(cfg_src))
      WD_SRC_SLOW:  src_tick = slow_tick;
      WD_SRC_INSTR: src_tick = instr_tick & ~halted;
      default:      src_tick = 1'b0;
    endcase
  end

  assign cnt_tick = cfg_enable & src_tick;

endmodule

// File: rtl/wdog_divider.sv
module wdog_divider
  import wdog_pkg::*;
#(
  parameter int unsigned BASE_EXP = 12,
  parameter int unsigned SEL_W    = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnt_tick,
  input  logic             clr_evt,
  input  logic [SEL_W-1:0] cfg_exp,
  output logic             wrap_evt,
  output logic             ovf_evt
);

  localparam int unsigned PW = BASE_EXP + (1 << SEL_W) - 1;

  logic [PW-1:0] presc_q;
  logic          armed_q;
  logic [PW-1:0] tap;

  // All-ones mask of the low n prescaler bits.
  function automatic logic [PW-1:0] tap_mask(input logic [SEL_W-1:0] sel);
    int unsigned n;
    n = wd_exp(BASE_EXP, sel);
    return (PW'(1) << n) - PW'(1);
  endfunction

  assign tap      = tap_mask(cfg_exp);
  assign wrap_evt = cnt_tick && ((presc_q & tap) == tap);
  assign ovf_evt  = wrap_evt && armed_q && !clr_evt;

  // Prescaler: only the external reset clears it.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        presc_q <= '0;
    else if (cnt_tick) presc_q <= presc_q + PW'(1);
  end

  // Armed stage: second wrap after a clear is the overflow.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        armed_q <= 1'b0;
    else if (clr_evt)  armed_q <= 1'b0;
    else if (wrap_evt) armed_q <= ~armed_q;
  end

endmodule

// File: rtl/wdog_reset_ctl.sv
module wdog_reset_ctl
  import wdog_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic ovf_evt,
  input  logic halted,
  input  logic sw_clr,
  output logic chip_rst_req,
  output logic warm_rst_req,
  output logic timeout_flag
);

  wd_act_e act;

  assign act = wd_action(ovf_evt, halted);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chip_rst_req <= 1'b0;
      warm_rst_req <= 1'b0;
    end else begin
      chip_rst_req <= (act == WD_ACT_CHIP);
      warm_rst_req <= (act == WD_ACT_WARM);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  timeout_flag <= 1'b0;
    else if (sw_clr)             timeout_flag <= 1'b0;
    else if (act == WD_ACT_CHIP) timeout_flag <= 1'b1;
  end

endmodule

// File: rtl/wdog_core.sv
module wdog_core
  import wdog_pkg::*;
#(
  parameter int unsigned BASE_EXP = 12
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_enable,
  input  logic       cfg_src,
  input  logic [1:0] cfg_exp,
  input  logic       slow_tick,
  input  logic       instr_tick,
  input  logic       clr_wdt,
  input  logic       halt_enter,
  input  logic       halted,
  output logic       chip_rst_req,
  output logic       warm_rst_req,
  output logic       timeout_flag
);

  // Named internal events, visible to the bound checker.
  logic cnt_tick;
  logic clr_evt;
  logic sw_clr;
  logic wrap_evt;
  logic ovf_evt;

  assign clr_evt = cfg_enable & (clr_wdt | halt_enter);
  assign sw_clr  = cfg_enable & clr_wdt;

  wdog_tick_sel u_tick_sel (
    .cfg_enable (cfg_enable),
    .cfg_src    (cfg_src),
    .slow_tick  (slow_tick),
    .instr_tick (instr_tick),
    .halted     (halted),
    .cnt_tick   (cnt_tick)
  );

  wdog_divider #(
    .BASE_EXP (BASE_EXP),
    .SEL_W    (2)
  ) u_divider (
    .clk      (clk),
    .rst_n    (rst_n),
    .cnt_tick (cnt_tick),
    .clr_evt  (clr_evt),
    .cfg_exp  (cfg_exp),
    .wrap_evt (wrap_evt),
    .ovf_evt  (ovf_evt)
  );

  wdog_reset_ctl u_reset_ctl (
    .clk          (clk),
    .rst_n        (rst_n),
    .ovf_evt      (ovf_evt),
    .halted       (halted),
    .sw_clr       (sw_clr),
    .chip_rst_req (chip_rst_req),
    .warm_rst_req (warm_rst_req),
    .timeout_flag (timeout_flag)
  );

endmodule

// File: rtl/wdog_core_chk.sv
module wdog_core_chk (
  input logic clk,
  input logic rst_n,
  input logic cfg_enable,
  input logic cfg_src,
  input logic clr_wdt,
  input logic halted,
  input logic clr_evt,
  input logic ovf_evt,
  input logic chip_rst_req,
  input logic warm_rst_req,
  input logic timeout_flag
);

  // R5
  chip_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chip_rst_req |=> !chip_rst_req);

  // R6
  warm_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    warm_rst_req |=> !warm_rst_req);

  // R5
  run_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_evt && !halted) |=> (chip_rst_req && !warm_rst_req && timeout_flag));

  // R6
  halt_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_evt && halted) |=> (warm_rst_req && !chip_rst_req && (timeout_flag == $past(timeout_flag))));

  // R7
  sw_clear_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_wdt && cfg_enable) |=> !timeout_flag);

  // R9
  instr_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_src && halted) |=> !warm_rst_req);

  // R10
  disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_enable |=> (!chip_rst_req && !warm_rst_req));

  // R11
  clear_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_evt |-> !ovf_evt);

  // R12
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (timeout_flag && !clr_wdt) |=> timeout_flag);

endmodule

bind wdog_core wdog_core_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cfg_enable   (cfg_enable),
  .cfg_src      (cfg_src),
  .clr_wdt      (clr_wdt),
  .halted       (halted),
  .clr_evt      (clr_evt),
  .ovf_evt      (ovf_evt),
  .chip_rst_req (chip_rst_req),
  .warm_rst_req (warm_rst_req),
  .timeout_flag (timeout_flag)
);

// File: tb/wdog_core_bench.sv
`timescale 1ns/1ps
module wdog_core_bench;

  localparam int BE = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_enable = 1'b0;
  logic       cfg_src = 1'b0;
  logic [1:0] cfg_exp = 2'd0;
  logic       slow_tick = 1'b0;
  logic       instr_tick = 1'b0;
  logic       clr_wdt = 1'b0;
  logic       halt_enter = 1'b0;
  logic       halted = 1'b0;
  logic       chip_rst_req;
  logic       warm_rst_req;
  logic       timeout_flag;

  int    total = 0;
  int    bad = 0;
  string cur_req = "R1";
  int    pulse_cnt = 0;

  // Reference model state
  int m_ticks = 0;
  int m_wraps = 0;
  bit e_chip = 1'b0;
  bit e_warm = 1'b0;
  bit e_flag = 1'b0;

  always #2.5 clk = ~clk;

  wdog_core #(.BASE_EXP(BE)) u_wdog_core (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_enable   (cfg_enable),
    .cfg_src      (cfg_src),
    .cfg_exp      (cfg_exp),
    .slow_tick    (slow_tick),
    .instr_tick   (instr_tick),
    .clr_wdt      (clr_wdt),
    .halt_enter   (halt_enter),
    .halted       (halted),
    .chip_rst_req (chip_rst_req),
    .warm_rst_req (warm_rst_req),
    .timeout_flag (timeout_flag)
  );

  // Behavioural model: tick count since reset, wraps since last clear.
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ticks = 0; m_wraps = 0;
      e_chip = 0; e_warm = 0; e_flag = 0;
    end else begin
      bit tk, clr, ovf;
      int per;
      per = 1 << (BE + int'(cfg_exp));
      tk  = cfg_enable && (cfg_src ? (instr_tick && !halted) : slow_tick);
      clr = cfg_enable && (clr_wdt || halt_enter);
      ovf = 1'b0;
      if (tk) begin
        m_ticks = m_ticks + 1;
        if (m_ticks % per == 0) begin
          if (m_wraps == 1 && !clr) ovf = 1'b1;
          m_wraps = (m_wraps == 1) ? 0 : 1;
        end
      end
      if (clr) m_wraps = 0;
      e_chip = ovf && !halted;
      e_warm = ovf && halted;
      if (e_chip) e_flag = 1'b1;
      if (cfg_enable && clr_wdt) e_flag = 1'b0;
    end
  end

  // Per-cycle comparison away from the active edge
  always @(negedge clk) begin
    total++;
    if (chip_rst_req || warm_rst_req) pulse_cnt++;
    if ({chip_rst_req, warm_rst_req, timeout_flag} !== {e_chip, e_warm, e_flag}) begin
      bad++;
      $display("FAIL %s cycle compare: actual chip/warm/flag=%b%b%b expected=%b%b%b",
               cur_req, chip_rst_req, warm_rst_req, timeout_flag, e_chip, e_warm, e_flag);
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk); #1;
  endtask

  task automatic do_reset(input bit en, input bit src, input logic [1:0] ex);
    slow_tick = 0; instr_tick = 0; clr_wdt = 0; halt_enter = 0;
    rst_n = 0;
    cfg_enable = en; cfg_src = src; cfg_exp = ex;
    cyc(); cyc();
    rst_n = 1;
    cyc();
  endtask

  task automatic drive_tick(input bit on);
    slow_tick  = on && !cfg_src;
    instr_tick = on && cfg_src;
  endtask

  task automatic tick_n(input int k);
    for (int i = 0; i < k; i++) begin
      drive_tick(1'b1);
      cyc();
    end
    drive_tick(1'b0);
  endtask

  task automatic wait_pulse(input int limit, output int got, output bit c, output bit w);
    got = -1; c = 0; w = 0;
    for (int i = 0; i < limit; i++) begin
      drive_tick(1'b1);
      cyc();
      if (chip_rst_req || warm_rst_req) begin
        got = i + 1; c = chip_rst_req; w = warm_rst_req;
        break;
      end
    end
    drive_tick(1'b0);
  endtask

  task automatic strobe_clr();
    clr_wdt = 1; cyc(); clr_wdt = 0;
  endtask

  task automatic strobe_halt();
    halt_enter = 1; cyc(); halt_enter = 0;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    int got, n, p0;
    bit c, w;

    // R1: reset state
    cur_req = "R1";
    do_reset(1'b1, 1'b0, 2'd0);
    check(!chip_rst_req && !warm_rst_req && !timeout_flag, "R1 reset outputs",
          {chip_rst_req, warm_rst_req, timeout_flag}, 0);

    // R3: every ratio, first and repeat period
    cur_req = "R3";
    for (int s = 0; s < 4; s++) begin
      n = BE + s;
      do_reset(1'b1, 1'b0, s[1:0]);
      wait_pulse(1000, got, c, w);
      check(c && got == (1 << (n + 1)), "R3 first overflow ticks", got, 1 << (n + 1));
      check(timeout_flag == 1'b1, "R5 flag after running overflow", timeout_flag, 1);
      wait_pulse(1000, got, c, w);
      check(c && got == (1 << (n + 1)), "R3 repeat period ticks", got, 1 << (n + 1));
    end

    // R4 and R7: clear mid-period keeps prescaler phase, clears flag
    cur_req = "R4";
    n = BE + 1;
    do_reset(1'b1, 1'b0, 2'd1);
    wait_pulse(1000, got, c, w);
    tick_n(3);
    strobe_clr();
    check(timeout_flag == 1'b0, "R7 clr_wdt clears flag", timeout_flag, 0);
    wait_pulse(1000, got, c, w);
    check(c && got == (1 << (n + 1)) - 3, "R4 timeout after clear", got, (1 << (n + 1)) - 3);

    // R8 and R12: halt entry clears counter, keeps flag
    cur_req = "R8";
    n = BE + 1;
    do_reset(1'b1, 1'b0, 2'd1);
    wait_pulse(1000, got, c, w);
    tick_n((1 << n) + 5);
    strobe_halt();
    check(timeout_flag == 1'b1, "R12 flag kept over halt_enter", timeout_flag, 1);
    wait_pulse(1000, got, c, w);
    check(c && got == (1 << (n + 1)) - 5, "R8 timeout after halt_enter", got, (1 << (n + 1)) - 5);

    // R11: clear on the overflowing tick
    cur_req = "R11";
    n = BE;
    do_reset(1'b1, 1'b0, 2'd0);
    wait_pulse(1000, got, c, w);
    tick_n((1 << (n + 1)) - 1);
    p0 = pulse_cnt;
    drive_tick(1'b1); clr_wdt = 1;
    cyc();
    drive_tick(1'b0); clr_wdt = 0;
    cyc();
    check(pulse_cnt == p0, "R11 overflow suppressed", pulse_cnt - p0, 0);
    wait_pulse(1000, got, c, w);
    check(c && got == (1 << (n + 1)), "R11 prescaler advanced on clear tick", got, 1 << (n + 1));

    // R6 and R12: halted overflow gives warm reset, flag unchanged
    cur_req = "R6";
    do_reset(1'b1, 1'b0, 2'd0);
    halted = 1;
    wait_pulse(1000, got, c, w);
    check(w && !c, "R6 warm only in halt", {c, w}, 1);
    check(timeout_flag == 1'b0, "R6 flag unchanged (clear)", timeout_flag, 0);
    halted = 0;
    wait_pulse(1000, got, c, w);
    check(c && !w, "R5 chip when running", {c, w}, 2);
    halted = 1;
    wait_pulse(1000, got, c, w);
    check(w && timeout_flag, "R12 flag kept over halted overflow", timeout_flag, 1);
    halted = 0;

    // R9: instruction source freezes in halt
    cur_req = "R9";
    n = BE;
    do_reset(1'b1, 1'b1, 2'd0);
    halted = 1;
    p0 = pulse_cnt;
    tick_n(600);
    check(pulse_cnt == p0, "R9 no overflow while frozen", pulse_cnt - p0, 0);
    halted = 0;
    wait_pulse(1000, got, c, w);
    check(c && got == (1 << (n + 1)), "R9 count resumed from frozen value", got, 1 << (n + 1));

    // R2: unselected tick ignored
    cur_req = "R2";
    do_reset(1'b1, 1'b0, 2'd0);
    p0 = pulse_cnt;
    instr_tick = 1; repeat (600) cyc(); instr_tick = 0;
    check(pulse_cnt == p0, "R2 instr_tick ignored on slow source", pulse_cnt - p0, 0);
    do_reset(1'b1, 1'b1, 2'd0);
    slow_tick = 1; repeat (600) cyc(); slow_tick = 0;
    check(pulse_cnt == p0, "R2 slow_tick ignored on instr source", pulse_cnt - p0, 0);

    // R10: disabled
    cur_req = "R10";
    do_reset(1'b0, 1'b0, 2'd0);
    p0 = pulse_cnt;
    slow_tick = 1; instr_tick = 1;
    for (int i = 0; i < 40; i++) begin
      repeat (20) cyc();
      clr_wdt = 1; halt_enter = 1; cyc(); clr_wdt = 0; halt_enter = 0;
    end
    slow_tick = 0; instr_tick = 0;
    cyc();
    check(pulse_cnt == p0, "R10 no request when disabled", pulse_cnt - p0, 0);
    check(timeout_flag == 1'b0, "R10 flag stays clear", timeout_flag, 0);

    cyc();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule